// File: doc/BRIEF.md
# Strip Readout Frame Processor

This block sits behind the digitizer of a silicon strip readout channel. It takes one signed sample per clock from a multiplexed analog stream. Between events the stream rests at a low idle level. A short high header marks the start of an event, and the header is followed by one amplitude per strip, 128 in all. The block recognizes the header and captures the frame. While capturing, it subtracts a stored pedestal from each strip and accumulates the results.

Once the frame is complete, the block takes the mean of the pedestal-subtracted values as that event's common-mode offset. It removes this offset from every buffered strip, then compares each strip with its own stored noise figure scaled by a programmable factor. Only strips above threshold leave the block, as index and amplitude pairs, framed by start and end markers. A single write port loads the pedestal and noise tables.

A frame that arrives before the previous one has been fully read out cannot be buffered. It is discarded whole and flagged.

Top module: `strip_frame_proc`

## Requirements
- R1: After reset, out_valid, out_sof, out_eof and overflow are low, and the block waits for a header.
- R2: While waiting, a frame begins after 3 consecutive samples that are signed-greater than cfg_hdr_level. A run of fewer such samples starts nothing. The 128 samples after the header are strips 0 to 127 in that order.
- R3: If a header completes while the previous frame is still being read out, overflow pulses high for exactly one cycle. The 128 samples of the new frame are then skipped and produce no output, and later frames are processed normally.
- R4: With tbl_we high at a clock edge, tbl_ped and tbl_noise are stored for strip tbl_addr. Each captured sample has its own strip's stored pedestal subtracted.
- R5: The common mode of a frame is floor(S/128), where S is the signed sum of its 128 pedestal-subtracted values (an arithmetic right shift by 7). It is subtracted from every strip of that frame.
- R6: A strip is a hit when its corrected amplitude is signed-strictly greater than its stored noise (unsigned) times cfg_hit_factor (unsigned). Equality is not a hit, and a factor of 0 makes every positive strip a hit.
- R7: Hits leave in ascending strip order with out_valid high. out_strip carries the strip index and out_amp carries the corrected amplitude in 16-bit two's complement.
- R8: Each processed frame gives exactly one out_sof pulse, on the beat that reports strip 0, and one out_eof pulse 127 cycles later, on the beat that reports strip 127. Both pulses appear whether or not those strips are hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sample | input | 16 | Signed digitized stream sample |
| cfg_hdr_level | input | 16 | Signed header detection level |
| cfg_hit_factor | input | 8 | Unsigned multiplier applied to strip noise |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Strip index being written |
| tbl_ped | input | 16 | Signed pedestal to store |
| tbl_noise | input | 16 | Unsigned noise figure to store |
| out_valid | output | 1 | A hit strip is presented |
| out_strip | output | 7 | Index of the presented strip |
| out_amp | output | 16 | Signed corrected amplitude |
| out_sof | output | 1 | Strip 0 scan beat of a frame |
| out_eof | output | 1 | Strip 127 scan beat of a frame |
| overflow | output | 1 | One-cycle pulse: overlapping frame dropped |

## Verification
The bench sweeps the hit factor across a range of values on the same frame. It also drives frames with positive and negative common modes, where the sum is not a multiple of 128. A design that rounds the negative mean toward zero, or that uses >= for the threshold, emits a different hit list. Both the equality case and the one-above case are built explicitly.

Hits on strips 0 and 127 expose off-by-one errors in the index counter or in the marker placement. A two-sample header run catches a detector that starts a frame too early. A frame sent during readout checks that the dropped data leaves no partial output and does not disturb the next frame. A pedestal rewritten through the table port checks that writes reach the intended strip.

// File: rtl/strip_frame_proc.sv
module strip_frame_proc #(
  parameter int NSTRIP  = 128,
  parameter int DW      = 16,
  parameter int FW      = 8,
  parameter int HDR_RUN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_sample,
  input  logic [DW-1:0] cfg_hdr_level,
  input  logic [FW-1:0] cfg_hit_factor,
  input  logic          tbl_we,
  input  logic [$clog2(NSTRIP)-1:0] tbl_addr,
  input  logic [DW-1:0] tbl_ped,
  input  logic [DW-1:0] tbl_noise,
  output logic          out_valid,
  output logic [$clog2(NSTRIP)-1:0] out_strip,
  output logic [DW-1:0] out_amp,
  output logic          out_sof,
  output logic          out_eof,
  output logic          overflow
);
  localparam int IW = $clog2(NSTRIP);
  localparam int SW = DW + IW;
  localparam int TW = DW + FW;
  localparam int HW = $clog2(HDR_RUN + 1);
  localparam logic [IW-1:0] LAST = IW'(NSTRIP - 1);

  typedef enum logic [1:0] {A_IDLE, A_CAP, A_DROP} acq_t;

  logic [DW-1:0] ped_mem   [NSTRIP];
  logic [DW-1:0] noise_mem [NSTRIP];
  logic [DW-1:0] frame_buf [NSTRIP];

  acq_t          acq;
  logic [HW-1:0] hcnt;
  logic [IW-1:0] widx, ridx;
  logic [SW-1:0] acc;
  logic [DW-1:0] cm;
  logic          rd_busy;

  always_ff @(posedge clk)
    if (tbl_we) begin
      ped_mem[tbl_addr]   <= tbl_ped;
      noise_mem[tbl_addr] <= tbl_noise;
    end

  wire           hdr_hit  = $signed(in_sample) > $signed(cfg_hdr_level);
  wire           hdr_done = (acq == A_IDLE) && hdr_hit && (hcnt == HW'(HDR_RUN - 1));
  wire [DW-1:0]  diff     = in_sample - ped_mem[widx];
  wire [SW-1:0]  sum_next = acc + {{IW{diff[DW-1]}}, diff};
  wire           cap_end  = (acq == A_CAP) && (widx == LAST);

  always_ff @(posedge clk)
    if (acq == A_CAP) frame_buf[widx] <= diff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq      <= A_IDLE;
      hcnt     <= '0;
      widx     <= '0;
      acc      <= '0;
      cm       <= '0;
      overflow <= 1'b0;
    end else begin
      overflow <= 1'b0;
      case (acq)
        A_IDLE: begin
          if (hdr_done) begin
            hcnt <= '0;
            widx <= '0;
            acc  <= '0;
            if (rd_busy) begin
              acq      <= A_DROP;
              overflow <= 1'b1;
            end else begin
              acq <= A_CAP;
            end
          end else if (hdr_hit) begin
            hcnt <= hcnt + 1'b1;
          end else begin
            hcnt <= '0;
          end
        end
        A_CAP: begin
          acc  <= sum_next;
          widx <= widx + 1'b1;
          if (widx == LAST) begin
            acq <= A_IDLE;
            cm  <= DW'($signed(sum_next) >>> IW);
          end
        end
        A_DROP: begin
          widx <= widx + 1'b1;
          if (widx == LAST) acq <= A_IDLE;
        end
        default: acq <= A_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_busy <= 1'b0;
      ridx    <= '0;
    end else if (cap_end) begin
      rd_busy <= 1'b1;
      ridx    <= '0;
    end else if (rd_busy) begin
      ridx <= ridx + 1'b1;
      if (ridx == LAST) rd_busy <= 1'b0;
    end
  end

  wire [DW-1:0] corr   = frame_buf[ridx] - cm;
  wire [TW-1:0] thr    = noise_mem[ridx] * cfg_hit_factor;
  wire          is_hit = $signed({{(FW + 1){corr[DW-1]}}, corr}) > $signed({1'b0, thr});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_strip <= '0;
      out_amp   <= '0;
    end else begin
      out_valid <= rd_busy && is_hit;
      out_sof   <= rd_busy && (ridx == '0);
      out_eof   <= rd_busy && (ridx == LAST);
      out_strip <= ridx;
      out_amp   <= corr;
    end
  end
endmodule

// File: rtl/strip_frame_proc_chk.sv
module strip_frame_proc_chk #(
  parameter int NSTRIP = 128,
  parameter int DW     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      out_valid,
  input logic [$clog2(NSTRIP)-1:0] out_strip,
  input logic [DW-1:0]             out_amp,
  input logic                      out_sof,
  input logic                      out_eof,
  input logic                      overflow
);
  localparam int IW = $clog2(NSTRIP);
  logic [IW:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (out_sof) cnt <= (IW+1)'(1);
    else if (cnt != '0 && cnt < (IW+1)'(NSTRIP)) cnt <= cnt + 1'b1;
  end

  AST_SOF_NOT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !out_eof); // R8
  AST_EOF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> (cnt == (IW+1)'(NSTRIP - 1))); // R8
  AST_SOF_STRIP0: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (out_strip == '0)); // R7
  AST_STRIP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> (cnt != '0 && cnt < (IW+1)'(NSTRIP) && out_strip == cnt[IW-1:0])); // R7
  AST_HIT_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_amp) > 0)); // R6
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> !overflow); // R3
endmodule

bind strip_frame_proc strip_frame_proc_chk #(.NSTRIP(NSTRIP), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_strip(out_strip),
  .out_amp(out_amp), .out_sof(out_sof), .out_eof(out_eof), .overflow(overflow)
);

// File: tb/strip_frame_proc_test.sv
module strip_frame_proc_test;
  localparam int NS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_sample = 16'hFFCE;
  logic [15:0] cfg_hdr_level = 16'd1000;
  logic [7:0]  cfg_hit_factor = 8'd3;
  logic        tbl_we = 1'b0;
  logic [6:0]  tbl_addr = '0;
  logic [15:0] tbl_ped = '0;
  logic [15:0] tbl_noise = '0;
  logic        out_valid, out_sof, out_eof, overflow;
  logic [6:0]  out_strip;
  logic [15:0] out_amp;

  strip_frame_proc uut (
    .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .cfg_hdr_level(cfg_hdr_level),
    .cfg_hit_factor(cfg_hit_factor), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_ped(tbl_ped), .tbl_noise(tbl_noise), .out_valid(out_valid),
    .out_strip(out_strip), .out_amp(out_amp), .out_sof(out_sof),
    .out_eof(out_eof), .overflow(overflow)
  );

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  int ped_t[NS], noise_t[NS], raw[NS];
  int got_s[NS], got_a[NS];
  int got_n = 0, sof_n = 0, eof_n = 0, ovf_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && got_n < NS) begin
        got_s[got_n] = int'(out_strip);
        got_a[got_n] = int'($signed(out_amp));
        got_n++;
      end
      if (out_sof) sof_n++;
      if (out_eof) eof_n++;
      if (overflow) ovf_n++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int v);
    @(negedge clk);
    in_sample = 16'(v);
  endtask

  task automatic idle(int n);
    repeat (n) drive(-50);
  endtask

  task automatic send_frame(int gap);
    repeat (3) drive(2000);
    for (int k = 0; k < NS; k++) drive(raw[k]);
    idle(gap);
  endtask

  task automatic load_tables(int seed);
    for (int k = 0; k < NS; k++) begin
      ped_t[k]   = 40 + ((k * 13 + seed) % 60);
      noise_t[k] = 2 + ((k + seed) % 6);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 7'(k);
      tbl_ped = 16'(ped_t[k]); tbl_noise = 16'(noise_t[k]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic clear_obs();
    got_n = 0; sof_n = 0; eof_n = 0;
  endtask

  function automatic bit has_strip(int s);
    for (int i = 0; i < got_n; i++) if (got_s[i] == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_frame(int f, string req);
    int sum = 0, cm, c, en = 0;
    for (int k = 0; k < NS; k++) sum += raw[k] - ped_t[k];
    cm = sum >>> 7;
    for (int k = 0; k < NS; k++) begin
      c = raw[k] - ped_t[k] - cm;
      if (c > noise_t[k] * f) begin
        if (en < got_n) begin
          chk(got_s[en] == k, {req, " strip"}, got_s[en], k);
          chk(got_a[en] == c, {req, " amp"}, got_a[en], c);
        end
        en++;
      end
    end
    chk(got_n == en, {req, " hit count"}, got_n, en);
    chk(sof_n == 1, "R8 sof count", sof_n, 1);
    chk(eof_n == 1, "R8 eof count", eof_n, 1);
    clear_obs();
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(overflow == 0, "R1 overflow", int'(overflow), 0);
    chk(out_sof == 0 && out_eof == 0, "R1 markers", int'(out_sof) + int'(out_eof), 0);
    rst_n = 1'b1;
    load_tables(0);
    idle(5);

    // R5 positive common mode, hits on boundary strips (R7)
    for (int k = 0; k < NS; k++) raw[k] = ped_t[k] + 20 + ((k * 5) % 7) - 3;
    raw[0] += 200; raw[64] += 200; raw[127] += 200;
    cfg_hit_factor = 8'd3;
    send_frame(140);
    chk(has_strip(0) && has_strip(127), "R7 edge strips", got_n, 3);
    check_frame(3, "R5");

    // R5 negative common mode, sum not a multiple of 128
    for (int k = 0; k < NS; k++) raw[k] = ped_t[k] - 37 + ((k * 3) % 5) - 2;
    raw[10] += 150; raw[11] += 1;
    cfg_hit_factor = 8'd2;
    send_frame(140);
    check_frame(2, "R5 neg");

    // R6 factor sweep
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < NS; k++) raw[k] = ped_t[k] + 7 + ((k * 11) % 13) - 6;
      raw[33] += 40; raw[90] += 25;
      cfg_hit_factor = 8'(f);
      send_frame(140);
      check_frame(f, "R6 sweep");
    end

    // R6 equality is not a hit, one above is
    for (int k = 0; k < NS; k++) raw[k] = ped_t[k] + 10;
    raw[5] += noise_t[5] * 4;
    raw[6] += noise_t[6] * 4 + 1;
    cfg_hit_factor = 8'd4;
    send_frame(140);
    chk(!has_strip(5), "R6 equal not hit", int'(has_strip(5)), 0);
    chk(has_strip(6), "R6 above hit", int'(has_strip(6)), 1);
    check_frame(4, "R6 eq");

    // R2 short header run starts nothing
    repeat (2) drive(2000);
    for (int k = 0; k < NS; k++) drive(ped_t[k]);
    idle(140);
    chk(sof_n == 0 && got_n == 0, "R2 short header", sof_n + got_n, 0);
    clear_obs();
    for (int k = 0; k < NS; k++) raw[k] = ped_t[k] + 3;
    raw[77] += 100;
    cfg_hit_factor = 8'd1;
    send_frame(140);
    check_frame(1, "R2");

    // R3 overlapping frame is dropped whole
    for (int k = 0; k < NS; k++) raw[k] = ped_t[k] - 5;
    raw[40] += 90;
    cfg_hit_factor = 8'd2;
    ovf_n = 0;
    send_frame(5);
    repeat (3) drive(2000);
    for (int k = 0; k < NS; k++) drive(ped_t[k] + 500);
    idle(140);
    chk(ovf_n == 1, "R3 overflow pulse", ovf_n, 1);
    chk(!has_strip(0), "R3 no partial output", int'(has_strip(0)), 0);
    check_frame(2, "R3");
    for (int k = 0; k < NS; k++) raw[k] = ped_t[k] + 15;
    raw[100] += 60;
    send_frame(140);
    chk(ovf_n == 1, "R3 no second overflow", ovf_n, 1);
    check_frame(2, "R3 after");

    // R4 pedestal rewrite through the table port
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 7'd20;
    tbl_ped = 16'(ped_t[20] - 100); tbl_noise = 16'(noise_t[20]);
    @(negedge clk);
    tbl_we = 1'b0;
    for (int k = 0; k < NS; k++) raw[k] = ped_t[k] + 10;
    ped_t[20] = ped_t[20] - 100;
    cfg_hit_factor = 8'd5;
    send_frame(140);
    chk(has_strip(20), "R4 rewritten strip", int'(has_strip(20)), 1);
    check_frame(5, "R4");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule